// File: doc/BRIEF.md
# Load/Store Address Generator

A purely combinational unit that forms the memory address for single-word and single-byte load/store instructions. It takes the 32-bit instruction word, the base register value, the index register value and the current carry flag. From these it produces three results: the address to access, a flag that says whether the base register must be updated, and the value to write into it.

The offset comes from one of two sources. It is either a 12-bit unsigned immediate or the index register shifted by a constant amount. The offset is added to or subtracted from the base. The access uses either the updated value (pre-indexed) or the untouched base (post-indexed). Two instruction bits, byte access and load, are passed straight through for the memory stage.

The block sits between register read and the memory stage of a pipeline. It holds no state and has no clock.

Top module: `ldst_agu`

## Requirements
- R1: With instr[24]=1 and instr[21]=0, mem_addr equals base_val plus or minus the offset, and wb_en is 0.
- R2: With instr[24]=1 and instr[21]=1, mem_addr equals base_val plus or minus the offset, wb_en is 1 (unless R10 applies), and wb_val equals mem_addr.
- R3: With instr[24]=0, mem_addr equals base_val unchanged, and wb_en is 1 whatever instr[21] holds (unless R10 applies). wb_val is base_val plus or minus the offset.
- R4: instr[23]=1 adds the offset and instr[23]=0 subtracts it, modulo 2^32, in every indexing form.
- R5: With instr[25]=0 the offset is instr[11:0], zero-extended.
- R6: With instr[25]=1 and instr[6:5]=00, the offset is index_val shifted left by instr[11:7]. An amount of 0 leaves index_val unchanged.
- R7: instr[6:5]=01 is a logical right shift by instr[11:7]. An amount of 0 means a full-width shift, which gives 0.
- R8: instr[6:5]=10 is an arithmetic right shift by instr[11:7]. An amount of 0 means a full-width shift, so every bit becomes a copy of index_val[31].
- R9: instr[6:5]=11 is a rotate right by instr[11:7]. An amount of 0 instead gives {carry_in, index_val[31:1]}.
- R10: When the base register number instr[19:16] is 15, wb_en is 0.
- R11: is_byte follows instr[22] and is_load follows instr[20] in every form.
- R12: instr[4] has no effect on any output. The shift amount always comes from instr[11:7] and never from a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| base_val | input | DATA_W | Value of the base register |
| index_val | input | DATA_W | Value of the index register |
| carry_in | input | 1 | Current carry flag, used by the rotate-through-carry case |
| mem_addr | output | DATA_W | Address of the access |
| wb_en | output | 1 | Base register update enable |
| wb_val | output | DATA_W | Value for the base register update |
| is_byte | output | 1 | Byte access (instr[22]) |
| is_load | output | 1 | Load, not store (instr[20]) |

## Verification
The bench builds the block with its default DATA_W of 32 and the program-counter write-back guard enabled.

This configuration is small enough to sweep every combination of the four addressing bits. Each combination is crossed with all four shift kinds, all 32 shift amounts, both carry values and four operand sets. The operand sets include sign-bit and wrap-around cases, and one of them names register 15 as the base.

As a result, every zero-amount special case, the rotate-through-carry path, the write-back suppression and the ignored bit 4 are all reached in the same run.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
   // instruction bit positions the decode depends on
   localparam int unsigned BIT_REGOFS  = 25;
   localparam int unsigned BIT_PRE     = 24;
   localparam int unsigned BIT_UP      = 23;
   localparam int unsigned BIT_BYTE    = 22;
   localparam int unsigned BIT_WB      = 21;
   localparam int unsigned BIT_LOAD    = 20;
   localparam int unsigned BASE_LSB    = 16;
   localparam int unsigned IMM_W       = 12;
   localparam int unsigned AMT_LSB     = 7;
   localparam int unsigned AMT_W       = 5;
   localparam int unsigned KIND_LSB    = 5;
   localparam int unsigned REGNUM_W    = 4;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'b00,
      SK_RIGHT = 2'b01,
      SK_ARITH = 2'b10,
      SK_ROT   = 2'b11
   } shift_kind_e;
endpackage

// File: rtl/ldst_index_shifter.sv
module ldst_index_shifter
   import ldst_agu_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] rm_val,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              carry_in,
   output logic [DATA_W-1:0] sh_out
);
   localparam int unsigned WIDE_W = 2 * DATA_W;

   logic [WIDE_W-1:0] doubled;
   logic [WIDE_W-1:0] rot_wide;

   assign doubled  = {rm_val, rm_val};
   assign rot_wide = doubled >> amt;

   always_comb begin
      unique case (kind)
         SK_LEFT:  sh_out = rm_val << amt;
         SK_RIGHT: sh_out = (amt == '0) ? '0 : (rm_val >> amt);
         SK_ARITH: sh_out = (amt == '0) ? {DATA_W{rm_val[DATA_W-1]}}
                                        : DATA_W'($signed(rm_val) >>> amt);
         default:  sh_out = (amt == '0) ? {carry_in, rm_val[DATA_W-1:1]}
                                        : rot_wide[DATA_W-1:0];
      endcase
   end

   always_comb begin
      if (kind == SK_ROT && amt == '0)
         p_rrx_msb_carry_r9: assert (sh_out[DATA_W-1] == carry_in)
            else $error("rotate-through-carry top bit wrong");
      if (kind == SK_LEFT)
         p_lsl_low_zero_r6: assert ((sh_out & ((DATA_W'(1) << amt) - DATA_W'(1))) == '0)
            else $error("left shift left nonzero low bits");
      if (kind == SK_RIGHT && amt == '0)
         p_lsr_full_zero_r7: assert (sh_out == '0)
            else $error("full logical shift not zero");
   end
endmodule

// File: rtl/ldst_offset_apply.sv
module ldst_offset_apply #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] offset,
   input  logic              add_sel,
   output logic [DATA_W-1:0] adjusted
);
   logic [DATA_W-1:0] ofs_eff;

   assign ofs_eff  = add_sel ? offset : (~offset + DATA_W'(1));
   assign adjusted = base + ofs_eff;

   always_comb begin
      if (add_sel)
         p_add_inverse_r4: assert (adjusted - offset == base)
            else $error("add direction inconsistent");
      else
         p_sub_inverse_r4: assert (adjusted + offset == base)
            else $error("subtract direction inconsistent");
   end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_agu_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned PC_REG       = 15,
   parameter bit          GUARD_PC_WB  = 1'b1
) (
   input  logic [31:0]       instr,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] index_val,
   input  logic              carry_in,
   output logic [DATA_W-1:0] mem_addr,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_val,
   output logic              is_byte,
   output logic              is_load
);
   localparam int unsigned MAX_REG = (1 << REGNUM_W) - 1;

   if (DATA_W < 32) begin : g_bad_width
      $error("ldst_agu: DATA_W must be at least 32");
   end
   if (PC_REG > MAX_REG) begin : g_bad_pc
      $error("ldst_agu: PC_REG outside register number range");
   end

   logic                reg_ofs, pre_idx, up, wb_req;
   logic [REGNUM_W-1:0] base_num;
   logic [DATA_W-1:0]   imm_ofs, reg_ofs_val, offset, adjusted;
   logic                wb_raw;

   assign reg_ofs  = instr[BIT_REGOFS];
   assign pre_idx  = instr[BIT_PRE];
   assign up       = instr[BIT_UP];
   assign wb_req   = instr[BIT_WB];
   assign base_num = instr[BASE_LSB +: REGNUM_W];
   assign is_byte  = instr[BIT_BYTE];
   assign is_load  = instr[BIT_LOAD];
   assign imm_ofs  = DATA_W'(instr[IMM_W-1:0]);

   ldst_index_shifter #(.DATA_W(DATA_W)) u_shift (
      .rm_val   (index_val),
      .kind     (shift_kind_e'(instr[KIND_LSB +: 2])),
      .amt      (instr[AMT_LSB +: AMT_W]),
      .carry_in (carry_in),
      .sh_out   (reg_ofs_val)
   );

   assign offset = reg_ofs ? reg_ofs_val : imm_ofs;

   ldst_offset_apply #(.DATA_W(DATA_W)) u_apply (
      .base     (base_val),
      .offset   (offset),
      .add_sel  (up),
      .adjusted (adjusted)
   );

   assign mem_addr = pre_idx ? adjusted : base_val;
   assign wb_val   = adjusted;
   assign wb_raw   = !pre_idx || wb_req;

   if (GUARD_PC_WB) begin : g_pc_guard
      assign wb_en = wb_raw && (base_num != REGNUM_W'(PC_REG));
   end else begin : g_no_guard
      assign wb_en = wb_raw;
   end

   always_comb begin
      if (!pre_idx)
         p_post_uses_base_r3: assert (mem_addr == base_val)
            else $error("post-indexed address not the base");
      if (pre_idx && !wb_req)
         p_pre_no_wb_r1: assert (!wb_en)
            else $error("write-back without request");
      if (pre_idx && wb_en)
         p_pre_wb_same_r2: assert (wb_val == mem_addr)
            else $error("write-back value differs from address");
      if (GUARD_PC_WB && base_num == REGNUM_W'(PC_REG))
         p_pc_no_wb_r10: assert (!wb_en)
            else $error("write-back to program counter");
   end
endmodule

// File: tb/ldst_agu_bench.sv
module ldst_agu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 190000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic [31:0] base_val = '0, index_val = '0;
   logic        carry_in = 1'b0;
   logic [31:0] mem_addr, wb_val;
   logic        wb_en, is_byte, is_load;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldst_agu u_ldst_agu (
      .instr(instr), .base_val(base_val), .index_val(index_val),
      .carry_in(carry_in), .mem_addr(mem_addr), .wb_en(wb_en),
      .wb_val(wb_val), .is_byte(is_byte), .is_load(is_load)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %08h expected %08h (instr %08h)",
                  req, act, exp, instr);
      end
   endtask

   function automatic logic [31:0] model_shift(input logic [31:0] v,
         input int kind, input int amt, input bit c);
      logic [63:0] ext;
      case (kind)
         0: return v << amt;                                  // R6
         1: return (amt == 0) ? 32'h0 : v >> amt;             // R7
         2: begin                                             // R8
            ext = {{32{v[31]}}, v};
            return (amt == 0) ? {32{v[31]}} : ext[amt +: 32];
         end
         default: begin                                       // R9
            if (amt == 0) return {c, v[31:1]};
            return (v >> amt) | (v << (32 - amt));
         end
      endcase
   endfunction

   function automatic logic [31:0] pick_base(input int s);
      case (s)
         0: return 32'h0000_0100;
         1: return 32'hFFFF_FFF0;
         2: return 32'h8000_0000;
         default: return 32'h1234_5678;
      endcase
   endfunction

   function automatic logic [31:0] pick_index(input int s);
      case (s)
         0: return 32'hF000_00F1;
         1: return 32'h0000_1234;
         2: return 32'h8765_4321;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // reset state: all-zero instruction is post-indexed subtract of 0 (R3)
      base_val = 32'h0000_0040;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(mem_addr == 32'h40, "R3 reset addr", mem_addr, 32'h40);
      check(wb_en == 1'b1, "R3 reset wb_en", {31'b0, wb_en}, 32'h1);
      check(wb_val == 32'h40, "R4 reset wb_val", wb_val, 32'h40);
      rst = 1'b0;

      for (int k = 0; k < 16; k++)
      for (int kind = 0; kind < 4; kind++)
      for (int amt = 0; amt < 32; amt++)
      for (int s = 0; s < 4; s++)
      for (int c = 0; c < 2; c++) begin
         bit ri, pre, up, wq, bt, ld;
         logic [3:0]  rn;
         logic [31:0] ofs, adj, e_addr, e_val;
         bit          e_en;
         string       mtag, otag;
         ri = k[3]; pre = k[2]; up = k[1]; wq = k[0];
         bt = amt[0]; ld = amt[1];
         rn = (s == 3) ? 4'd15 : 4'(s + 2 * kind);
         @(negedge clk);
         instr = {4'hE, 2'b01, ri, pre, up, bt, wq, ld, rn, 4'h3,
                  5'(amt), 2'(kind), s[0], 4'(amt)};   // bit 4 toggles: R12
         base_val  = pick_base(s) ^ 32'(k * 32'h0101_0000);
         index_val = pick_index(s) ^ 32'(c * 32'h0000_0F00);
         carry_in  = c[0];
         #1;
         ofs = ri ? model_shift(index_val, kind, amt, c[0]) : {20'h0, instr[11:0]};
         adj = up ? base_val + ofs : base_val - ofs;                 // R4
         e_addr = pre ? adj : base_val;
         e_val  = adj;
         e_en   = (!pre || wq) && (rn != 4'd15);                     // R10
         mtag = pre ? (wq ? "R2" : "R1") : "R3";
         otag = ri ? (kind == 0 ? "R6" : kind == 1 ? "R7" :
                      kind == 2 ? "R8" : "R9") : "R5";
         check(mem_addr == e_addr, {mtag, " R4 R12 addr ", otag}, mem_addr, e_addr);
         check(wb_val == e_val, {mtag, " R4 wb_val ", otag}, wb_val, e_val);
         check(wb_en == e_en, {mtag, " R10 wb_en"}, {31'b0, wb_en}, {31'b0, e_en});
         check(is_byte == bt, "R11 is_byte", {31'b0, is_byte}, {31'b0, bt});
         check(is_load == ld, "R11 is_load", {31'b0, is_load}, {31'b0, ld});
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fails);
      $finish;
   end
endmodule